// File: doc/BRIEF.md
# IR Receiver Byte-Stream Packet Parser

This block sits behind an infrared receiver's sample buffer. It takes the raw byte stream that the receiver hands out and splits it into packets. Some packets are commands, which hold a header, a subcommand and a payload. The others are IR run packets, which hold a data header and a run of sample bytes. Each sample byte becomes one timed event: a pulse/space flag plus a duration, which is the 7-bit sample count times `SAMPLE_PERIOD`. An empty run header asks the downstream decoder to reset. Command payload bytes are consumed and dropped.

Bytes arrive with a valid qualifier. The final byte of a batch is flagged with `in_last`. After such a batch, `batch_evt` tells the consumer that fresh events are ready to hand to a protocol decoder.

The parser has four states:
- `ST_HDR` waits for a packet header.
- `ST_SUB` takes the subcommand.
- `ST_PAY` skips the payload.
- `ST_IRD` emits run samples.

Its transitions are:
- HDR→SUB on a command header.
- HDR→IRD on a non-empty run header.
- HDR→HDR on an empty run header.
- SUB→PAY when the looked-up length is non-zero.
- SUB→HDR when the looked-up length is zero.
- PAY→HDR and IRD→HDR when the remaining count reaches zero.

Top module: `ir_stream_parser`

## Requirements
- R1: After reset, `ev_valid`, `dec_rst` and `batch_evt` are low, and the first accepted byte is treated as a packet header.
- R2: In the header state, a byte is a command header if it equals 8'h9F or if its bits [7:5] are not 3'b100. Any other byte is a run header, and its bits [4:0] give the number of sample bytes that follow.
- R3: A run header of 8'h80 (length zero) raises `dec_rst` for exactly one cycle, produces no event and leaves the parser in the header state.
- R4: The payload length is looked up from the (header, subcommand) pair:
  - 9F with 06, 0C or 15 gives 2 bytes.
  - 9F with 01, 08 or 14 gives 1 byte.
  - FF with 0B gives 2 bytes.
  - 00 with FF gives 1 byte.
  - Every other pair gives 0 bytes.
- R5: Each sample byte of a run raises `ev_valid`. `ev_pulse` equals bit 7 of the byte, and `ev_dur` equals bits [6:0] times `SAMPLE_PERIOD`. After the counted number of samples, the parser is back in the header state.
- R6: Command subcommand and payload bytes produce no event. After the looked-up count (none at all for a zero count), the next byte is a header.
- R7: Cycles with `in_valid` low change neither the parser state nor the remaining count, and produce no output.
- R8: `batch_evt` pulses in the cycle after a byte with `in_last` is accepted, and only if that batch produced at least one sample event.
- R9: The outputs produced by a byte are registered and appear in the cycle after that byte is accepted, so back-to-back bytes are handled at one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Received stream byte |
| in_last | input | 1 | Marks the final byte of a batch |
| ev_valid | output | 1 | A sample event is present |
| ev_pulse | output | 1 | 1 = pulse, 0 = space |
| ev_dur | output | DUR_W | Scaled event duration |
| dec_rst | output | 1 | Decoder-reset strobe |
| batch_evt | output | 1 | Batch ended with events pending |

## Verification
The assertions check several rules on every cycle:
- The subcommand state is always left after one byte.
- A run returns to the header state after its last counted sample.
- Idle cycles hold the state and the remaining count.
- Event durations are whole multiples of the sample period.
- A reset strobe never coincides with an event.
- `batch_evt` only follows a last-flagged byte.

Only the bench scenarios can show the behaviours that depend on stream content:
- the exact payload length for each (header, subcommand) pair;
- that payload bytes shaped like run headers are still skipped;
- the polarity and duration values;
- the exact byte boundary at which parsing resumes after a packet.

// File: rtl/ir_parse_pkg.sv
package ir_parse_pkg;
    localparam int BYTE_W   = 8;
    localparam int SMP_W    = BYTE_W - 1;
    localparam int CNT_W    = 5;

    localparam logic [BYTE_W-1:0] KIND_MASK   = 8'hE0;
    localparam logic [BYTE_W-1:0] RUN_PATTERN = 8'h80;
    localparam logic [BYTE_W-1:0] CNT_MASK    = 8'h1F;

    localparam logic [BYTE_W-1:0] HDR_CMD  = 8'h9F;
    localparam logic [BYTE_W-1:0] HDR_HW   = 8'hFF;
    localparam logic [BYTE_W-1:0] HDR_NULL = 8'h00;

    localparam logic [BYTE_W-1:0] SUB_CARRIER = 8'h06;
    localparam logic [BYTE_W-1:0] SUB_TMO     = 8'h0C;
    localparam logic [BYTE_W-1:0] SUB_PCOUNT  = 8'h15;
    localparam logic [BYTE_W-1:0] SUB_SIGEND  = 8'h01;
    localparam logic [BYTE_W-1:0] SUB_TXMASK  = 8'h08;
    localparam logic [BYTE_W-1:0] SUB_RXSENS  = 8'h14;
    localparam logic [BYTE_W-1:0] SUB_REV     = 8'h0B;

    typedef enum logic [1:0] {
        ST_HDR = 2'd0,
        ST_SUB = 2'd1,
        ST_PAY = 2'd2,
        ST_IRD = 2'd3
    } pstate_t;
endpackage

// File: rtl/ir_len_lut.sv
module ir_len_lut
    import ir_parse_pkg::*;
(
    input  logic [BYTE_W-1:0] hdr,
    input  logic [BYTE_W-1:0] sub,
    output logic [1:0]        len
);
    always_comb begin
        len = 2'd0;
        if (hdr == HDR_CMD) begin
            if (sub == SUB_CARRIER || sub == SUB_TMO || sub == SUB_PCOUNT)
                len = 2'd2;
            else if (sub == SUB_SIGEND || sub == SUB_TXMASK || sub == SUB_RXSENS)
                len = 2'd1;
        end else if (hdr == HDR_HW) begin
            if (sub == SUB_REV)
                len = 2'd2;
        end else if (hdr == HDR_NULL) begin
            if (sub == HDR_HW)
                len = 2'd1;
        end
    end
endmodule

// File: rtl/ir_pkt_fsm.sv
module ir_pkt_fsm
    import ir_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              emit_ir,
    output logic              emit_rst
);
    pstate_t           st, st_n;
    logic [CNT_W-1:0]  rem, rem_n;
    logic [BYTE_W-1:0] cmd, cmd_n;
    logic [1:0]        lut_len;
    logic              is_cmd;
    logic [CNT_W-1:0]  hdr_len;

    ir_len_lut u_lut (
        .hdr (cmd),
        .sub (in_byte),
        .len (lut_len)
    );

    assign is_cmd  = (in_byte == HDR_CMD) || ((in_byte & KIND_MASK) != RUN_PATTERN);
    assign hdr_len = CNT_W'(in_byte & CNT_MASK);

    always_comb begin
        st_n     = st;
        rem_n    = rem;
        cmd_n    = cmd;
        emit_ir  = 1'b0;
        emit_rst = 1'b0;
        if (in_valid) begin
            unique case (st)
                ST_HDR: begin
                    cmd_n = in_byte;
                    if (is_cmd) begin
                        st_n = ST_SUB;
                    end else if (hdr_len == '0) begin
                        emit_rst = 1'b1;
                    end else begin
                        rem_n = hdr_len;
                        st_n  = ST_IRD;
                    end
                end
                ST_SUB: begin
                    rem_n = CNT_W'(lut_len);
                    st_n  = (lut_len == 2'd0) ? ST_HDR : ST_PAY;
                end
                ST_PAY: begin
                    rem_n = rem - 1'b1;
                    if (rem == CNT_W'(1)) st_n = ST_HDR;
                end
                ST_IRD: begin
                    emit_ir = 1'b1;
                    rem_n   = rem - 1'b1;
                    if (rem == CNT_W'(1)) st_n = ST_HDR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_HDR;
            rem <= '0;
            cmd <= '0;
        end else begin
            st  <= st_n;
            rem <= rem_n;
            cmd <= cmd_n;
        end
    end

    // R4 / R6: the subcommand state lasts exactly one accepted byte
    a_r4_sub_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUB && in_valid) |=> (st != ST_SUB));

    // R5: the last counted sample returns the parser to the header state
    a_r5_run_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IRD && in_valid && rem == CNT_W'(1)) |=> (st == ST_HDR));

    // R6: counting states always hold a live count
    a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAY || st == ST_IRD) |-> (rem != '0));

    // R7: idle cycles freeze the parser
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st) && $stable(rem)));
endmodule

// File: rtl/ir_evt_out.sv
module ir_evt_out
    import ir_parse_pkg::*;
#(
    parameter int SAMPLE_PERIOD = 50,
    parameter int DUR_W         = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              emit_ir,
    input  logic              emit_rst,
    output logic              ev_valid,
    output logic              ev_pulse,
    output logic [DUR_W-1:0]  ev_dur,
    output logic              dec_rst,
    output logic              batch_evt
);
    localparam logic [DUR_W-1:0] PERIOD_V = DUR_W'(SAMPLE_PERIOD);

    logic             seen;
    logic [DUR_W-1:0] dur_calc;

    assign dur_calc = DUR_W'(in_byte[SMP_W-1:0]) * PERIOD_V;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid  <= 1'b0;
            ev_pulse  <= 1'b0;
            ev_dur    <= '0;
            dec_rst   <= 1'b0;
            batch_evt <= 1'b0;
            seen      <= 1'b0;
        end else begin
            ev_valid  <= emit_ir;
            dec_rst   <= emit_rst;
            batch_evt <= 1'b0;
            if (emit_ir) begin
                ev_pulse <= in_byte[BYTE_W-1];
                ev_dur   <= dur_calc;
            end
            if (in_valid) begin
                if (in_last) begin
                    batch_evt <= seen | emit_ir;
                    seen      <= 1'b0;
                end else begin
                    seen <= seen | emit_ir;
                end
            end
        end
    end

    // R8: the batch strobe only follows an accepted last byte
    a_r8_pend_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        batch_evt |-> $past(in_valid && in_last));

    // R5: every duration is a whole number of sample periods
    a_r5_dur_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> ((ev_dur % PERIOD_V) == '0));

    // R3: a decoder reset never coincides with a sample event
    a_r3_rst_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && dec_rst));
endmodule

// File: rtl/ir_stream_parser.sv
module ir_stream_parser
    import ir_parse_pkg::*;
#(
    parameter  int SAMPLE_PERIOD = 50,
    localparam int DUR_W         = SMP_W + $clog2(SAMPLE_PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic              ev_valid,
    output logic              ev_pulse,
    output logic [DUR_W-1:0]  ev_dur,
    output logic              dec_rst,
    output logic              batch_evt
);
    logic emit_ir;
    logic emit_rst;

    ir_pkt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .emit_ir  (emit_ir),
        .emit_rst (emit_rst)
    );

    ir_evt_out #(
        .SAMPLE_PERIOD (SAMPLE_PERIOD),
        .DUR_W         (DUR_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_byte   (in_byte),
        .emit_ir   (emit_ir),
        .emit_rst  (emit_rst),
        .ev_valid  (ev_valid),
        .ev_pulse  (ev_pulse),
        .ev_dur    (ev_dur),
        .dec_rst   (dec_rst),
        .batch_evt (batch_evt)
    );

    // R9: registered outputs are quiet in the cycle after an idle input
    a_r9_registered: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!ev_valid && !dec_rst && !batch_evt));
endmodule

// File: tb/ir_stream_parser_bench.sv
module ir_stream_parser_bench;
    localparam int PER   = 50;
    localparam int DUR_W = 7 + $clog2(PER + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = '0;
    logic             in_last = 1'b0;
    logic             ev_valid, ev_pulse, dec_rst, batch_evt;
    logic [DUR_W-1:0] ev_dur;

    int n_chk  = 0;
    int n_fail = 0;

    logic             o_ev, o_pol, o_rst, o_pend;
    logic [DUR_W-1:0] o_dur;

    always #10 clk = ~clk;

    ir_stream_parser #(.SAMPLE_PERIOD(PER)) u_ir_stream_parser (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_byte (in_byte),
        .in_last (in_last), .ev_valid (ev_valid), .ev_pulse (ev_pulse),
        .ev_dur (ev_dur), .dec_rst (dec_rst), .batch_evt (batch_evt)
    );

    task automatic capture();
        o_ev = ev_valid; o_pol = ev_pulse; o_dur = ev_dur;
        o_rst = dec_rst; o_pend = batch_evt;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic last);
        in_valid = 1'b1; in_byte = b; in_last = last;
        @(posedge clk); @(negedge clk);
        capture();
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
        capture();
    endtask

    task automatic quiet(input string tag);
        chk({tag, " no event"}, int'(o_ev), 0);
        chk({tag, " no reset"}, int'(o_rst), 0);
    endtask

    task automatic expect_ev(input string tag, input logic [7:0] b);
        chk({tag, " ev_valid"}, int'(o_ev), 1);
        chk({tag, " polarity"}, int'(o_pol), int'(b[7]));
        chk({tag, " duration"}, int'(o_dur), int'(b[6:0]) * PER);
    endtask

    task automatic t_reset();
        chk("R1 ev_valid after reset", int'(ev_valid), 0);
        chk("R1 dec_rst after reset", int'(dec_rst), 0);
        chk("R1 batch_evt after reset", int'(batch_evt), 0);
        push(8'h81, 1'b0); quiet("R1 first byte is header");
        push(8'h07, 1'b1); expect_ev("R1 sample after header", 8'h07);
        chk("R8 pend after event batch", int'(o_pend), 1);
    endtask

    task automatic t_ir_run();
        push(8'h83, 1'b0); quiet("R2 run header");
        chk("R9 no early pend", int'(o_pend), 0);
        push(8'h8A, 1'b0); expect_ev("R5 sample1", 8'h8A);
        push(8'h05, 1'b0); expect_ev("R5 sample2", 8'h05);
        push(8'hFF, 1'b1); expect_ev("R5 sample3 max", 8'hFF);
        chk("R8 pend run", int'(o_pend), 1);
        idle(); chk("R9 event one cycle", int'(o_ev), 0);
        chk("R8 pend one cycle", int'(o_pend), 0);
        push(8'h81, 1'b0); quiet("R5 back to header");
        push(8'h01, 1'b1); expect_ev("R5 next run", 8'h01);
    endtask

    task automatic t_zero();
        push(8'h80, 1'b1);
        chk("R3 dec_rst", int'(o_rst), 1);
        chk("R3 no event", int'(o_ev), 0);
        chk("R8 no pend without events", int'(o_pend), 0);
        idle(); chk("R3 single cycle", int'(o_rst), 0);
        push(8'h82, 1'b0); quiet("R3 still header");
        push(8'h11, 1'b0); expect_ev("R3 run a", 8'h11);
        push(8'h92, 1'b1); expect_ev("R3 run b", 8'h92);
    endtask

    task automatic t_cmd(input logic [7:0] h, input logic [7:0] s,
                         input int n, input string tag);
        push(h, 1'b0); quiet({tag, " R2 cmd header"});
        push(s, 1'b0); quiet({tag, " R6 subcmd"});
        for (int i = 0; i < n; i++) begin
            push(8'h85, 1'b0); quiet({tag, " R6 payload skipped"});
        end
        push(8'h81, 1'b0); quiet({tag, " R4 resync header"});
        push(8'h07, 1'b1); expect_ev({tag, " R4 length"}, 8'h07);
    endtask

    task automatic t_idle();
        push(8'h82, 1'b0);
        for (int i = 0; i < 4; i++) begin
            idle(); quiet("R7 idle gap");
        end
        push(8'h20, 1'b0); expect_ev("R7 after gap", 8'h20);
        idle(); idle();
        push(8'hC0, 1'b1); expect_ev("R7 second after gap", 8'hC0);
        chk("R8 pend after gaps", int'(o_pend), 1);
    endtask

    task automatic t_batch();
        push(8'h81, 1'b0);
        push(8'h10, 1'b0); expect_ev("R8 mid event", 8'h10);
        push(8'h9F, 1'b0);
        push(8'h01, 1'b0);
        push(8'h33, 1'b1); quiet("R8 last is payload");
        chk("R8 pend carried", int'(o_pend), 1);
        push(8'h9F, 1'b0);
        push(8'h08, 1'b0);
        push(8'h44, 1'b1);
        chk("R8 pend cleared per batch", int'(o_pend), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ir_run();
        t_zero();
        t_cmd(8'h9F, 8'h06, 2, "carrier");
        t_cmd(8'h9F, 8'h0C, 2, "timeout");
        t_cmd(8'h9F, 8'h15, 2, "pcount");
        t_cmd(8'h9F, 8'h01, 1, "sigend");
        t_cmd(8'h9F, 8'h08, 1, "txmask");
        t_cmd(8'h9F, 8'h14, 1, "rxsens");
        t_cmd(8'hFF, 8'h0B, 2, "revision");
        t_cmd(8'h00, 8'hFF, 1, "nullhw");
        t_cmd(8'h9F, 8'h02, 0, "unknown");
        t_cmd(8'h00, 8'h0B, 0, "nullrev");
        t_cmd(8'h40, 8'h06, 0, "othercmd");
        t_cmd(8'hFF, 8'h06, 0, "hwcarrier");
        t_idle();
        t_batch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule